// File: doc/BRIEF.md
# Microcoded Memory-Cycle Pattern Sequencer

This block runs short microprograms held in a small array of control words. Each word drives external memory strobes and picks an address source for one cycle. The block serves six kinds of bus request: single read, burst read, single write, burst write, refresh service and a software-issued run. A request of a given kind starts execution at that kind's programmed entry index. The sequencer then steps through the array until it reaches the word flagged as final.

A word can re-execute itself in place for up to three extra cycles. This inserts wait states without using more array entries. The repeat combines with three other features in a defined way: transfer acknowledge is raised on every repeat, the address advances on every repeat, and the loop mechanism still counts and branches. The output address comes from one of three sources: the running transaction address, a row form of the latched address taken at a shift chosen by a mode input, or a holding register. Illegal field combinations raise a configuration error output.

Top module: `mcyc_seq`

## Requirements
- R1: While idle, a request with `req_valid` high and `req_type` of 0 (single read), 1 (burst read), 2 (single write), 3 (burst write), 4 (refresh service) or 5 (run) sets `busy` on the next cycle and executes the word at that type's entry index, taken from bits `[t*IW +: IW]` of `start_idx`. Requests made while busy, and requests with type 6 or 7, are ignored.
- R2: Array entry i is bits `[i*12 +: 12]` of `pattern`. Bits [1:0] of a word are a repeat count; the word executes for repeat+1 consecutive cycles before the sequencer moves on.
- R3: When bit 3 (acknowledge) of the current word is set, `ta` is high in every execution cycle of that word, repeats included.
- R4: When bit 2 (increment) of the current word is set, the transaction address advances by one after every execution cycle of that word, repeats included.
- R5: Bit 4 is the loop flag. The first loop word met outside a loop marks the loop start and loads the count. The next loop word at a different index marks the loop end; it branches back to the start until the body has run count+1 times. A loop word's repeat count still applies on each pass.
- R6: The loop count is taken from `rd_loop` for types 0, 1 and 5, from `wr_loop` for types 2 and 3, and from `tmr_loop` for type 4.
- R7: Bit 5 marks the final word. The sequence ends after that word, and `done` is high for exactly the first idle cycle that follows. A final word with a nonzero repeat count runs only once and raises `cfg_err` while it executes.
- R8: Bits [7:6] select the address source. 00 drives the transaction address (the latched request address plus increments) on `mem_addr`, and 11 drives `mar`.
- R9: Source 10 drives zero on `mem_addr[AW-1:16]` and drives bits [15:0] of the latched request address shifted right by 8+`am_sel` on `mem_addr[15:0]`. Increments do not affect this value.
- R10: Source 01 behaves like 00 and raises `cfg_err` while that word executes.
- R11: Bits [11:8] of the current word appear on `mem_ctl` while busy. While idle, `mem_ctl`, `ta`, `mem_addr` and `cfg_err` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_type | input | 3 | Request kind code |
| req_addr | input | AW | Transaction address |
| start_idx | input | 6*IW | Entry index per request kind |
| pattern | input | NW*12 | Control word array |
| rd_loop | input | LW | Loop count for reads and run |
| wr_loop | input | LW | Loop count for writes |
| tmr_loop | input | LW | Loop count for refresh service |
| am_sel | input | 2 | Row shift selector for source 10 |
| mar | input | AW | Holding register value |
| busy | output | 1 | Sequence in progress |
| mem_ctl | output | 4 | Memory control strobes |
| ta | output | 1 | Transfer acknowledge |
| mem_addr | output | AW | Memory address |
| cfg_err | output | 1 | Illegal word fields |
| done | output | 1 | Sequence completed pulse |

## Verification
The hardest situation to reach from the ports is a repeated loop-start word inside a loop whose count comes from a type-specific field. Here the repeat, the return to the loop start and the count all interact. The bench loads a four-word loop program and sweeps every repeat value against every loop count and every request type. It then checks the cycle count and the acknowledge count against closed-form totals. A second sweep covers every combination of repeat, acknowledge and increment and checks the address in each cycle. During one long loop run, a request is injected in the middle to show that it is dropped.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int CTL_W   = 4;
    localparam int WORD_W  = 12;
    localparam int NTYPES  = 6;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [1:0]       amx;
        logic             last;
        logic             loop;
        logic             uta;
        logic             na;
        logic [1:0]       redo;
    } cw_t;

    typedef enum logic [2:0] {
        RQ_RD1 = 3'd0,
        RQ_RDB = 3'd1,
        RQ_WR1 = 3'd2,
        RQ_WRB = 3'd3,
        RQ_RFS = 3'd4,
        RQ_RUN = 3'd5
    } req_e;

    typedef enum logic [1:0] {
        SRC_TXN  = 2'b00,
        SRC_RSV  = 2'b01,
        SRC_ROW  = 2'b10,
        SRC_HOLD = 2'b11
    } asrc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    function automatic logic type_ok(input logic [2:0] t);
        return t < 3'(NTYPES);
    endfunction

    function automatic logic word_illegal(input cw_t w);
        return (w.last && (w.redo != 2'd0)) || (w.amx == SRC_RSV);
    endfunction

endpackage

// File: rtl/mcyc_lpsel.sv
module mcyc_lpsel
    import mcyc_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic [2:0]    req_type,
    input  logic [LW-1:0] rd_loop,
    input  logic [LW-1:0] wr_loop,
    input  logic [LW-1:0] tmr_loop,
    output logic [LW-1:0] loop_val
);
    always_comb begin
        case (req_type)
            RQ_WR1, RQ_WRB: loop_val = wr_loop;
            RQ_RFS:         loop_val = tmr_loop;
            default:        loop_val = rd_loop;
        endcase
    end
endmodule

// File: rtl/mcyc_step.sv
module mcyc_step
    import mcyc_pkg::*;
#(
    parameter int NW = 16,
    parameter int LW = 4,
    localparam int IW = $clog2(NW)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [2:0]            req_type,
    input  logic [NTYPES*IW-1:0]  start_idx,
    input  logic [NW*WORD_W-1:0]  pattern,
    input  logic [LW-1:0]         loop_val,
    output logic                  accept,
    output logic                  busy,
    output cw_t                   cur_w,
    output logic                  done
);
    cw_t           pat   [NW];
    logic [IW-1:0] entry [8];

    for (genvar i = 0; i < NW; i++) begin : g_unpack
        assign pat[i] = cw_t'(pattern[i*WORD_W +: WORD_W]);
    end

    for (genvar t = 0; t < 8; t++) begin : g_entry
        if (t < NTYPES) begin : g_used
            assign entry[t] = start_idx[t*IW +: IW];
        end else begin : g_spare
            assign entry[t] = '0;
        end
    end

    st_e           state;
    logic [IW-1:0] idx;
    logic [IW-1:0] lstart;
    logic [1:0]    rep;
    logic [LW-1:0] lcnt;
    logic [LW-1:0] lval_q;
    logic          in_loop;
    logic          more;

    assign busy   = (state == ST_RUN);
    assign cur_w  = pat[idx];
    assign accept = (state == ST_IDLE) && req_valid && type_ok(req_type);
    assign more   = busy && (rep != cur_w.redo) && !cur_w.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            lstart  <= '0;
            rep     <= '0;
            lcnt    <= '0;
            lval_q  <= '0;
            in_loop <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state   <= ST_RUN;
                idx     <= entry[req_type];
                rep     <= '0;
                in_loop <= 1'b0;
                lval_q  <= loop_val;
            end else if (busy) begin
                if (more) begin
                    rep <= rep + 2'd1;
                end else begin
                    rep <= '0;
                    if (cur_w.last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (cur_w.loop) begin
                        if (!in_loop) begin
                            in_loop <= 1'b1;
                            lstart  <= idx;
                            lcnt    <= lval_q;
                            idx     <= idx + IW'(1);
                        end else if (idx == lstart) begin
                            idx <= idx + IW'(1);
                        end else if (lcnt != '0) begin
                            lcnt <= lcnt - LW'(1);
                            idx  <= lstart;
                        end else begin
                            in_loop <= 1'b0;
                            idx     <= idx + IW'(1);
                        end
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
            end
        end
    end

    // R2: a repeating word holds its index and keeps the sequence running
    p_redo_hold_r2: assert property (@(posedge clk) disable iff (rst)
        more |=> busy && $stable(idx));

    // R7: the final word ends the sequence with a done pulse
    p_last_end_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_w.last) |=> (!busy && done));

    // R1: without an accepted request an idle sequencer stays idle
    p_idle_stay_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !accept) |=> !busy);

    // R7: done only follows an executing cycle
    p_done_after_run_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
endmodule

// File: rtl/mcyc_addr.sv
module mcyc_addr
    import mcyc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int AM_BASE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic          busy,
    input  cw_t           cur_w,
    input  logic [1:0]    am_sel,
    input  logic [AW-1:0] mar,
    output logic [AW-1:0] mem_addr
);
    localparam int ROW_W = 16;

    logic [AW-1:0]    base_q;
    logic [AW-1:0]    inc_q;
    logic [AW-1:0]    txn;
    logic [ROW_W-1:0] row;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            inc_q  <= '0;
        end else if (accept) begin
            base_q <= req_addr;
            inc_q  <= '0;
        end else if (busy && cur_w.na) begin
            inc_q <= inc_q + AW'(1);
        end
    end

    assign txn = base_q + inc_q;
    assign row = ROW_W'(base_q >> (AM_BASE + int'(am_sel)));

    always_comb begin
        mem_addr = '0;
        if (busy) begin
            case (cur_w.amx)
                SRC_ROW:  mem_addr = {{(AW-ROW_W){1'b0}}, row};
                SRC_HOLD: mem_addr = mar;
                default:  mem_addr = txn;
            endcase
        end
    end

    // R4: every execution cycle of an incrementing word advances the address
    p_na_step_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_w.na) |=> (inc_q == $past(inc_q) + AW'(1)));

    // R9: row source keeps the upper address lines low
    p_row_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_w.amx == SRC_ROW) |-> (mem_addr[AW-1:ROW_W] == '0));
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcyc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NW      = 16,
    parameter int LW      = 4,
    parameter int AM_BASE = 8,
    localparam int IW     = $clog2(NW)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [2:0]            req_type,
    input  logic [AW-1:0]         req_addr,
    input  logic [NTYPES*IW-1:0]  start_idx,
    input  logic [NW*WORD_W-1:0]  pattern,
    input  logic [LW-1:0]         rd_loop,
    input  logic [LW-1:0]         wr_loop,
    input  logic [LW-1:0]         tmr_loop,
    input  logic [1:0]            am_sel,
    input  logic [AW-1:0]         mar,
    output logic                  busy,
    output logic [CTL_W-1:0]      mem_ctl,
    output logic                  ta,
    output logic [AW-1:0]         mem_addr,
    output logic                  cfg_err,
    output logic                  done
);
    logic [LW-1:0] loop_val;
    logic          accept;
    cw_t           cur_w;

    mcyc_lpsel #(.LW(LW)) u_lpsel (
        .req_type (req_type),
        .rd_loop  (rd_loop),
        .wr_loop  (wr_loop),
        .tmr_loop (tmr_loop),
        .loop_val (loop_val)
    );

    mcyc_step #(.NW(NW), .LW(LW)) u_step (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_type  (req_type),
        .start_idx (start_idx),
        .pattern   (pattern),
        .loop_val  (loop_val),
        .accept    (accept),
        .busy      (busy),
        .cur_w     (cur_w),
        .done      (done)
    );

    mcyc_addr #(.AW(AW), .AM_BASE(AM_BASE)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_addr (req_addr),
        .busy     (busy),
        .cur_w    (cur_w),
        .am_sel   (am_sel),
        .mar      (mar),
        .mem_addr (mem_addr)
    );

    assign ta      = busy && cur_w.uta;
    assign mem_ctl = busy ? cur_w.ctl : '0;
    assign cfg_err = busy && word_illegal(cur_w);

    // R3: acknowledge never appears outside a sequence
    p_ta_busy_r3: assert property (@(posedge clk) disable iff (rst)
        ta |-> busy);

    // R11: idle outputs are quiet
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_addr == '0 && !ta && !cfg_err && mem_ctl == '0));

    // R7: a final word carrying a repeat count is flagged
    p_last_redo_err_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_w.last && cur_w.redo != 2'd0) |-> cfg_err);
endmodule

// File: tb/mcyc_seq_bench.sv
module mcyc_seq_bench;
    localparam int AW = 32;
    localparam int NW = 16;
    localparam int LW = 4;
    localparam int IW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [2:0]        req_type = '0;
    logic [AW-1:0]     req_addr = '0;
    logic [6*IW-1:0]   start_idx = '0;
    logic [NW*12-1:0]  pattern = '0;
    logic [LW-1:0]     rd_loop = '0, wr_loop = '0, tmr_loop = '0;
    logic [1:0]        am_sel = '0;
    logic [AW-1:0]     mar = '0;
    logic              busy, ta, cfg_err, done;
    logic [3:0]        mem_ctl;
    logic [AW-1:0]     mem_addr;

    mcyc_seq u_mcyc_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .start_idx(start_idx), .pattern(pattern),
        .rd_loop(rd_loop), .wr_loop(wr_loop), .tmr_loop(tmr_loop),
        .am_sel(am_sel), .mar(mar), .busy(busy), .mem_ctl(mem_ctl),
        .ta(ta), .mem_addr(mem_addr), .cfg_err(cfg_err), .done(done)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    int          ncyc, nta;
    logic [31:0] addrs [256];
    logic        errs  [256];
    logic [3:0]  first_ctl;
    logic        done_q, done2;
    logic        inject = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mkw(input logic [3:0] ctl, input logic [1:0] amx,
                                        input logic last, input logic loop, input logic uta,
                                        input logic na, input logic [1:0] redo);
        return {ctl, amx, last, loop, uta, na, redo};
    endfunction

    task automatic setw(input int i, input logic [11:0] w);
        pattern[i*12 +: 12] = w;
    endtask

    task automatic sets(input int t, input logic [3:0] ix);
        start_idx[t*IW +: IW] = ix;
    endtask

    task automatic run(input logic [2:0] t, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_type = t; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        ncyc = 0; nta = 0; first_ctl = mem_ctl;
        while (busy && ncyc < 250) begin
            addrs[ncyc] = mem_addr;
            errs[ncyc]  = cfg_err;
            if (ta) nta++;
            ncyc++;
            if (inject && ncyc == 3) begin
                req_valid = 1'b1; req_type = 3'd1; req_addr = 32'hDEAD_0000;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        done_q = done;
        @(negedge clk);
        done2 = done;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(!busy && !ta && !cfg_err && !done, "R11 reset flags", {busy, ta, cfg_err, done}, 0);
        chk(mem_addr == 0 && mem_ctl == 0, "R11 reset outputs", mem_addr, 0);

        // R2 R3 R4 R7 R11: repeat x acknowledge x increment sweep
        sets(0, 4'd0);
        for (int r = 0; r < 4; r++)
            for (int u = 0; u < 2; u++)
                for (int n = 0; n < 2; n++) begin
                    logic [31:0] a;
                    a = 32'h1000_0040 + 32'(r * 16);
                    setw(0, mkw(4'h5, 2'b00, 1'b0, 1'b0, u[0], n[0], r[1:0]));
                    setw(1, mkw(4'h9, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
                    run(3'd0, a);
                    chk(ncyc == r + 2, "R2 cycles", ncyc, r + 2);
                    chk(nta == u * (r + 1), "R3 ack count", nta, u * (r + 1));
                    for (int k = 0; k <= r + 1; k++)
                        chk(addrs[k] == a + 32'(n * k), "R4 address", addrs[k], a + 32'(n * k));
                    chk(first_ctl == 4'h5, "R11 ctl field", first_ctl, 5);
                    chk(done_q && !done2, "R7 done pulse", {done_q, done2}, 2'b10);
                end

        // R5 R6: loop sweep over count, repeat and request type
        for (int t = 0; t < 6; t++) sets(t, 4'd4);
        setw(5, mkw(4'h2, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0));
        setw(6, mkw(4'h3, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
        setw(7, mkw(4'h4, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
        for (int l = 0; l < 4; l++)
            for (int r = 0; r < 4; r++)
                for (int t = 0; t < 6; t++) begin
                    int le;
                    rd_loop = 4'(l); wr_loop = 4'((l + 1) % 4); tmr_loop = 4'((l + 2) % 4);
                    le = (t == 2 || t == 3) ? (l + 1) % 4 : (t == 4) ? (l + 2) % 4 : l;
                    setw(4, mkw(4'h1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, r[1:0]));
                    run(3'(t), 32'h100);
                    chk(ncyc == (le + 1) * (r + 3) + 1, "R5 R6 loop cycles", ncyc, (le + 1) * (r + 3) + 1);
                    chk(nta == le + 1, "R5 body passes", nta, le + 1);
                end

        // R1: request in mid-sequence is dropped
        rd_loop = 4'd3;
        setw(4, mkw(4'h1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3));
        inject = 1'b1;
        run(3'd0, 32'h200);
        inject = 1'b0;
        chk(ncyc == 25, "R1 busy request ignored", ncyc, 25);
        chk(!busy, "R1 no restart", busy, 0);

        // R1: reserved type codes ignored
        for (int t = 6; t < 8; t++) begin
            @(negedge clk); req_valid = 1'b1; req_type = 3'(t);
            @(negedge clk); req_valid = 1'b0;
            chk(!busy && mem_ctl == 0, "R1 reserved type", busy, 0);
        end

        // R7: final word with repeat count
        sets(1, 4'd8);
        setw(8, mkw(4'h3, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2));
        run(3'd1, 32'h300);
        chk(ncyc == 1, "R7 last+repeat runs once", ncyc, 1);
        chk(errs[0], "R7 cfg_err", errs[0], 1);
        chk(nta == 1, "R7 single ack", nta, 1);
        chk(done_q, "R7 done", done_q, 1);

        // R9 R4: row source ignores increments
        sets(3, 4'd9);
        setw(9,  mkw(4'h6, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2));
        setw(10, mkw(4'h7, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
        for (int m = 0; m < 4; m++) begin
            logic [31:0] a, rowe;
            a = 32'hABCD_1234;
            am_sel = 2'(m);
            rowe = (a >> (8 + m)) & 32'h0000_FFFF;
            run(3'd3, a);
            for (int k = 0; k < 3; k++)
                chk(addrs[k] == rowe, "R9 row address", addrs[k], rowe);
            chk(addrs[3] == a + 3, "R4 column after repeats", addrs[3], a + 3);
            chk(!errs[0], "R9 no error", errs[0], 0);
        end

        // R8 R10: holding register and reserved source
        sets(2, 4'd11);
        mar = 32'h5555_0007;
        setw(11, mkw(4'h8, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0));
        setw(12, mkw(4'h8, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
        run(3'd2, 32'h0000_4000);
        chk(addrs[0] == mar, "R8 hold source", addrs[0], mar);
        chk(!errs[0], "R8 no error", errs[0], 0);
        chk(addrs[1] == 32'h0000_4001, "R10 reserved as txn", addrs[1], 32'h0000_4001);
        chk(errs[1], "R10 cfg_err", errs[1], 1);

        // R1: per-type entry index
        sets(0, 4'd13); sets(1, 4'd14); sets(4, 4'd15);
        setw(13, mkw(4'hA, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
        setw(14, mkw(4'hB, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
        setw(15, mkw(4'hC, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
        run(3'd0, 0); chk(first_ctl == 4'hA, "R1 entry type0", first_ctl, 4'hA);
        run(3'd1, 0); chk(first_ctl == 4'hB, "R1 entry type1", first_ctl, 4'hB);
        run(3'd4, 0); chk(first_ctl == 4'hC, "R1 entry type4", first_ctl, 4'hC);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule